// File: doc/BRIEF.md
# Hot-Swap Switch Control FSM

This block sequences the input hot-swap switch of a powered line interface. It has four states: Off, Inrush, On and Overload. An undervoltage-lockout enable starts it. Three comparator flags on the voltage across the switch move it between states, and an on-die temperature reading can force it open. All decisions are taken on the cycles where a 1 µs timebase tick is high. On every other cycle the state holds and the inputs are ignored.

The block does not include the analog current-limit loops or the comparators. It drives a two-bit mode code that selects one of four switch settings: open, the inrush current limit (about 170 mA), fully on, or the low overload current limit (about 10.5 mA). It also reports its state code. Inside the block are the thermal hysteresis latch, a persistence filter that qualifies an overvoltage before Overload is entered, and a dwell timer that keeps the switch in Overload for a minimum time.

Top module: `hs_switch_ctrl`

## Requirements
- R1: After reset the state code is 0 (Off) and the mode is 0 (open). While `pwr_en` is low the block stays in Off. From Off, the only possible next states are Off and Inrush.
- R2: In Off, a tick with `pwr_en` high and the thermal latch clear moves the block to state 1 (Inrush), with mode 1 (inrush current limit).
- R3: In Inrush, a tick with `v_lt_inrush_exit` high moves the block to state 2 (On), with mode 2 (fully on). A tick with the flag low keeps it in Inrush.
- R4: In On, the block moves to state 3 (Overload), with mode 3 (low current limit), on the QUAL_TICKS-th consecutive tick that has `v_gt_ovld` high. With fewer consecutive ticks it stays in On.
- R5: A tick with `v_gt_ovld` low while in On restarts the persistence count. A later overload then needs a full QUAL_TICKS run again.
- R6: Let the tick that entered Overload count as tick 0. The block leaves Overload no earlier than tick DWELL_TICKS after it, even when `v_lt_ovld_exit` is high earlier.
- R7: Once the dwell time has passed, Overload returns to On only on a tick with `v_lt_ovld_exit` high. Ticks without the flag keep it in Overload.
- R8: A tick with `temp_c` >= TRIP_C sets the thermal latch and forces Off from any state. The latch clears on a tick with `temp_c` <= TRIP_C-HYST_C. Re-entry to Inrush can happen on that same tick. While the latch is set the state is Off.
- R9: A tick with `pwr_en` low returns the block to Off from any state.
- R10: The state changes only on cycles where `tick` is high. Flag changes on cycles without a tick have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | 1 µs timebase strobe, one clock wide |
| pwr_en | input | 1 | Enable from undervoltage lockout |
| v_lt_inrush_exit | input | 1 | Switch voltage below the inrush exit level (380 mV) |
| v_lt_ovld_exit | input | 1 | Switch voltage below the overload exit level (360 mV) |
| v_gt_ovld | input | 1 | Switch voltage above the overload entry level (3.6 V) |
| temp_c | input | TEMP_W | Die temperature in °C |
| sw_mode | output | 2 | 0 open, 1 inrush limit, 2 fully on, 3 low limit |
| hs_state | output | 2 | 0 Off, 1 Inrush, 2 On, 3 Overload |

## Verification
Some properties are checked on every cycle:
- The state holds on cycles without a tick.
- Off, a disable and a thermal trip lead to the correct next state.
- On cannot reach Overload unless the persistence filter fires.
- Overload cannot return to On before the dwell timer is done.
- The thermal latch is never set while the state is anything but Off.

Other behaviours are shown only by the bench's scenarios, because they depend on exact counts over long tick runs:
- The exact tick on which Overload is entered.
- The count restarting after the flag drops.
- The exact tick on which Overload is left.
- The hysteresis band, where the switch stays open.

// File: rtl/hs_ctrl_pkg.sv
package hs_ctrl_pkg;

  typedef enum logic [1:0] {
    HS_OFF    = 2'd0,
    HS_INRUSH = 2'd1,
    HS_ON     = 2'd2,
    HS_OVLD   = 2'd3
  } hs_state_e;

  typedef enum logic [1:0] {
    SW_OPEN    = 2'd0,
    SW_ILIM_HI = 2'd1,
    SW_FULL    = 2'd2,
    SW_ILIM_LO = 2'd3
  } sw_mode_e;

  // switch setting requested in each state
  function automatic sw_mode_e mode_for(hs_state_e s);
    case (s)
      HS_INRUSH: return SW_ILIM_HI;
      HS_ON:     return SW_FULL;
      HS_OVLD:   return SW_ILIM_LO;
      default:   return SW_OPEN;
    endcase
  endfunction

  // thermal latch with hysteresis: set at trip, clear at trip-hyst or below
  function automatic logic therm_update(logic cur, logic [31:0] temp,
                                        logic [31:0] trip, logic [31:0] hyst);
    if (temp >= trip)             return 1'b1;
    else if (temp <= trip - hyst) return 1'b0;
    else                          return cur;
  endfunction

  // persistence filter fires on the limit-th consecutive high sample
  function automatic logic persist_fire(logic flag, logic [31:0] cnt,
                                        logic [31:0] limit);
    return flag && (cnt + 32'd1 >= limit);
  endfunction

  // dwell satisfied once elapsed ticks (cnt+1 on this tick) reach limit
  function automatic logic dwell_met(logic [31:0] cnt, logic [31:0] limit);
    return (cnt + 32'd1 >= limit);
  endfunction

endpackage

// File: rtl/hs_therm_latch.sv
module hs_therm_latch
  import hs_ctrl_pkg::*;
#(
  parameter int TEMP_W = 9,
  parameter int TRIP_C = 160,
  parameter int HYST_C = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TEMP_W-1:0] temp_c,
  output logic              hot_next,
  output logic              hot_q
);

  always_comb begin
    if (tick) hot_next = therm_update(hot_q, 32'(temp_c), TRIP_C, HYST_C);
    else      hot_next = hot_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot_next;
  end

endmodule

// File: rtl/hs_persist.sv
module hs_persist
  import hs_ctrl_pkg::*;
#(
  parameter int LIMIT = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  input  logic flag,
  output logic fire
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign fire = arm && tick && persist_fire(flag, 32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!arm)            cnt_q <= '0;
    else if (tick) begin
      if (!flag || fire)      cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/hs_dwell.sv
module hs_dwell
  import hs_ctrl_pkg::*;
#(
  parameter int LIMIT = 80000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic arm,
  output logic met
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign met = arm && dwell_met(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!arm)          cnt_q <= '0;
    else if (tick && !met)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/hs_switch_ctrl.sv
module hs_switch_ctrl
  import hs_ctrl_pkg::*;
#(
  parameter int TEMP_W      = 9,
  parameter int TRIP_C      = 160,
  parameter int HYST_C      = 20,
  parameter int QUAL_TICKS  = 140,
  parameter int DWELL_TICKS = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_en,
  input  logic              v_lt_inrush_exit,
  input  logic              v_lt_ovld_exit,
  input  logic              v_gt_ovld,
  input  logic [TEMP_W-1:0] temp_c,
  output logic [1:0]        sw_mode,
  output logic [1:0]        hs_state
);

  hs_state_e state_q, state_d;
  logic      hot_next, hot_q;
  logic      force_off;
  logic      qual_fire;
  logic      dwell_ok;

  hs_therm_latch #(.TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)) u_therm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .temp_c(temp_c),
    .hot_next(hot_next), .hot_q(hot_q)
  );

  hs_persist #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(state_q == HS_ON),
    .flag(v_gt_ovld), .fire(qual_fire)
  );

  hs_dwell #(.LIMIT(DWELL_TICKS)) u_dwell (
    .clk(clk), .rst_n(rst_n), .tick(tick), .arm(state_q == HS_OVLD),
    .met(dwell_ok)
  );

  assign force_off = tick && (!pwr_en || hot_next);

  always_comb begin
    state_d = state_q;
    if (force_off) begin
      state_d = HS_OFF;
    end else if (tick) begin
      case (state_q)
        HS_OFF:    state_d = HS_INRUSH;
        HS_INRUSH: if (v_lt_inrush_exit) state_d = HS_ON;
        HS_ON:     if (qual_fire) state_d = HS_OVLD;
        HS_OVLD:   if (dwell_ok && v_lt_ovld_exit) state_d = HS_ON;
        default:   state_d = HS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_OFF;
    else        state_q <= state_d;
  end

  assign hs_state = state_q;
  assign sw_mode  = mode_for(state_q);

endmodule

// File: rtl/hs_switch_ctrl_chk.sv
module hs_switch_ctrl_chk #(
  parameter int TEMP_W = 9,
  parameter int TRIP_C = 160,
  parameter int HYST_C = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              pwr_en,
  input logic              v_lt_inrush_exit,
  input logic [TEMP_W-1:0] temp_c,
  input logic [1:0]        hs_state,
  input logic              hot_q,
  input logic              qual_fire,
  input logic              dwell_ok
);

  localparam logic [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] CLR_T  = TEMP_W'(TRIP_C - HYST_C);

  p_legal_from_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hs_state == 2'd0 |=> (hs_state == 2'd0 || hs_state == 2'd1));

  p_enable_to_inrush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwr_en && hs_state == 2'd0 && temp_c <= CLR_T) |=> hs_state == 2'd1);

  p_inrush_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwr_en && hs_state == 2'd1 && v_lt_inrush_exit && temp_c < TRIP_T)
      |=> hs_state == 2'd2);

  p_no_unqualified_ovld_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_state == 2'd2 && !qual_fire) |=> hs_state != 2'd3);

  p_dwell_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_state == 2'd3 && !dwell_ok) |=> hs_state != 2'd2);

  p_thermal_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && temp_c >= TRIP_T) |=> hs_state == 2'd0);

  p_hot_forces_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_q |-> hs_state == 2'd0);

  p_disable_to_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwr_en) |=> hs_state == 2'd0);

  p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hs_state));

endmodule

bind hs_switch_ctrl hs_switch_ctrl_chk #(
  .TEMP_W(TEMP_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_en(pwr_en),
  .v_lt_inrush_exit(v_lt_inrush_exit), .temp_c(temp_c), .hs_state(hs_state),
  .hot_q(hot_q), .qual_fire(qual_fire), .dwell_ok(dwell_ok)
);

// File: tb/tb_hs_switch_ctrl.sv
module tb_hs_switch_ctrl;

  localparam int QUAL  = 6;
  localparam int DWELL = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       pwr_en = 1'b0;
  logic       v_lt_inrush_exit = 1'b0;
  logic       v_lt_ovld_exit = 1'b0;
  logic       v_gt_ovld = 1'b0;
  logic [8:0] temp_c = 9'd25;
  logic [1:0] sw_mode, hs_state;

  int checks = 0;
  int fails = 0;
  int q_st[$];
  string q_req[$];
  logic tick_seen = 1'b0;

  always #10 clk = ~clk;

  hs_switch_ctrl #(.TEMP_W(9), .TRIP_C(160), .HYST_C(20),
                   .QUAL_TICKS(QUAL), .DWELL_TICKS(DWELL)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_en(pwr_en),
    .v_lt_inrush_exit(v_lt_inrush_exit), .v_lt_ovld_exit(v_lt_ovld_exit),
    .v_gt_ovld(v_gt_ovld), .temp_c(temp_c), .sw_mode(sw_mode), .hs_state(hs_state)
  );

  // expected switch setting per state, from the requirement encodings
  function automatic int want_mode(int st);
    int m;
    m = 0;
    if (st == 1) m = 1;
    if (st == 2) m = 2;
    if (st == 3) m = 3;
    return m;
  endfunction

  task automatic compare(int exp_st, string req);
    checks++;
    if (int'(hs_state) != exp_st || int'(sw_mode) != want_mode(exp_st)) begin
      fails++;
      $display("FAIL %s: state=%0d mode=%0d expected state=%0d mode=%0d",
               req, hs_state, sw_mode, exp_st, want_mode(exp_st));
    end
  endtask

  // monitor: one expected item per tick edge, compared at the next falling edge
  always @(posedge clk) tick_seen <= tick;
  always @(negedge clk) begin
    if (tick_seen && q_st.size() > 0) begin
      int s;
      string r;
      s = q_st.pop_front();
      r = q_req.pop_front();
      compare(s, r);
    end
  end

  // driver: apply inputs with one tick and push the expected outcome
  task automatic step(logic en, logic bi, logic br, logic ga, int t,
                      int exp_st, string req);
    @(negedge clk);
    pwr_en = en; v_lt_inrush_exit = bi; v_lt_ovld_exit = br; v_gt_ovld = ga;
    temp_c = 9'(t); tick = 1'b1;
    q_st.push_back(exp_st);
    q_req.push_back(req);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(0, "R1 reset state");
    step(0, 0, 0, 0, 25, 0, "R1 held off while disabled");
    step(1, 0, 0, 0, 25, 1, "R2 enable enters inrush");
    // R10: flag pulse without a tick must not move the state
    @(negedge clk); v_lt_inrush_exit = 1'b1;
    @(negedge clk); v_lt_inrush_exit = 1'b0;
    compare(1, "R10 no change without tick");
    step(1, 0, 0, 0, 25, 1, "R3 inrush holds with flag low");
    step(1, 1, 0, 0, 25, 2, "R3 inrush exits to on");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 25, 2, "R5 short overvoltage run");
    step(1, 0, 0, 0, 25, 2, "R5 flag drop restarts count");
    for (int i = 0; i < QUAL - 1; i++) step(1, 0, 0, 1, 25, 2, "R4 not yet qualified");
    step(1, 0, 0, 1, 25, 3, "R4 qualified overload entry");
    for (int i = 1; i < DWELL; i++) step(1, 0, 1, 0, 25, 3, "R6 dwell holds overload");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 25, 3, "R7 no exit without low voltage");
    step(1, 0, 1, 0, 25, 2, "R7 exit to on after dwell");
    step(1, 0, 0, 0, 170, 0, "R8 thermal trip forces off");
    step(1, 0, 0, 0, 150, 0, "R8 hysteresis band stays off");
    step(1, 0, 0, 0, 141, 0, "R8 just above release stays off");
    step(1, 0, 0, 0, 140, 1, "R8 release re-enters inrush");
    step(1, 1, 0, 0, 25, 2, "R3 back to on");
    step(0, 0, 0, 0, 25, 0, "R9 disable from on");
    step(1, 0, 0, 0, 25, 1, "R2 re-enable");
    step(0, 0, 0, 0, 25, 0, "R9 disable from inrush");
    step(1, 0, 0, 0, 25, 1, "R2 re-enable again");
    step(1, 1, 0, 0, 25, 2, "R3 on again");
    for (int i = 0; i < QUAL - 1; i++) step(1, 0, 0, 1, 25, 2, "R4 qualifying");
    step(1, 0, 0, 1, 25, 3, "R4 overload again");
    step(1, 0, 1, 0, 25, 3, "R6 early low voltage ignored");
    step(0, 0, 1, 0, 25, 0, "R9 disable from overload");
    step(1, 0, 0, 0, 25, 1, "R2 enable after overload loss");
    step(1, 0, 0, 0, 165, 0, "R8 thermal trip from inrush");
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule